// File: doc/BRIEF.md
# Dual-Group Thread Pick Scheduler

This block selects which hardware threads issue each cycle in a core that runs eight threads. The threads are split into two fixed groups of four. Threads 0 to 3 form group 0 and threads 4 to 7 form group 1. Each cycle the block makes one pick in each group, and the two picks are made independently. Within a group, the pick goes to the ready thread that has waited longest since it last issued.

Each thread reports whether its instruction buffer holds an instruction. It also reports a 2-bit class for the instruction at the head of that buffer. The picks are registered into a decode slot, one slot per group. There a conflict check guards the load/store unit and the floating-point unit, which all eight threads share. If both decode slots need the same shared unit, one group issues and the other group stalls. The stalled group keeps its instruction and retries on the next cycle, and the group that lost the last conflict wins the next one.

Top module: `dual_group_picker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no thread issues and the stall flag is low. Reset sets the recency order in each group to ascending thread id, with the lowest id the least recent. Reset also makes group 0 the winner of the next shared-unit conflict.
- R2: Group 0 holds threads 0 to 3 and reports on `issue_vld[0]` and `issue_tid[2:0]`. Group 1 holds threads 4 to 7 and reports on `issue_vld[1]` and `issue_tid[5:3]`. Thread ids are global, so group 1 reports the values 4 to 7. At most one thread per group issues in a cycle.
- R3: Within a group, the pick goes to the ready thread that issued least recently. A thread whose ready bit is low is skipped. If no thread in a group is ready, that group issues nothing.
- R4: The ready bits and classes of one group have no effect on the pick made in the other group.
- R5: A pick made from the inputs sampled at a clock edge appears on `issue_vld`, `issue_tid` and `stall` right after that edge. The latency is one cycle.
- R6: Each thread has a class field at `thr_class[2t+1:2t]`. The encodings are 00 integer, 01 load/store, 10 floating-point and 11 integer (reserved). A conflict exists when both decode slots are valid and both hold class 01, or both hold class 10. On a conflict exactly one group issues and `stall` is high. Any other combination issues both slots and keeps `stall` low.
- R7: On a conflict, the group that lost the previous conflict wins. The first conflict after reset is won by group 0.
- R8: The losing group keeps its decoded thread and class and does not take a new pick. It offers the same thread again on the next cycle.
- R9: The recency order changes only when a thread issues, and the issuing thread then becomes the most recent in its group. A stalled thread keeps its place until it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | 8 | Bit t is high when thread t has an instruction ready |
| thr_class | input | 16 | Two bits per thread: class of its head instruction |
| issue_vld | output | 2 | Bit g is high when group g issues this cycle |
| issue_tid | output | 6 | Three bits per group: global id of the thread in its decode slot |
| stall | output | 1 | High when a shared-unit conflict stalls one group |

## Verification
The least-recently-issued pick and the shared-unit conflict check act in the same cycle. A conflict stalls one group, and that has two effects: it freezes that group's pick stage, and it holds back that group's recency update. The benches provoke this with both groups requesting the load/store unit for several cycles in a row, and with mixed load/store and floating-point pairs. Each cycle they check which group wins the alternation, that the held thread reappears with the same id, and that the next pick in the stalled group follows the recency order that only the issued threads have moved.

// File: rtl/dgp_pkg.sv
// Shared types for the dual-group thread pick scheduler.
// Assumes a 2-bit instruction class per thread.
package dgp_pkg;

    typedef enum logic [1:0] {
        CLS_INT  = 2'b00,
        CLS_LDST = 2'b01,
        CLS_FPU  = 2'b10,
        CLS_RSV  = 2'b11
    } ins_class_e;

    localparam int CLS_W = 2;

    // True when the class needs a unit shared by both groups
    function automatic logic needs_shared(input ins_class_e c);
        return (c == CLS_LDST) || (c == CLS_FPU);
    endfunction

endpackage

// File: rtl/dgp_group_arb.sv
// One group's pick stage and decode slot.
// Keeps a recency list of its threads, with the least recent at index 0.
// Picks the first ready thread in that list and registers the pick.
// Assumes: hold comes from the conflict stage and freezes the slot.
module dgp_group_arb
    import dgp_pkg::*;
#(
    parameter int TPG   = 4,
    parameter int LID_W = $clog2(TPG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TPG-1:0]       ready,
    input  logic [TPG*CLS_W-1:0] cls_in,
    input  logic                 hold,
    output logic                 dec_vld,
    output logic [LID_W-1:0]     dec_lid,
    output ins_class_e           dec_cls
);
    localparam int ORD_W = TPG * LID_W;

    logic [ORD_W-1:0] rec_q;
    logic [ORD_W-1:0] view;
    logic             found;
    logic [LID_W-1:0] pick;
    logic             issue;

    // Ascending order used at reset
    function automatic logic [ORD_W-1:0] init_order();
        logic [ORD_W-1:0] o;
        o = '0;
        for (int i = 0; i < TPG; i++) o[i*LID_W +: LID_W] = LID_W'(i);
        return o;
    endfunction

    // Move id to the most-recent end, keeping the others in order
    function automatic logic [ORD_W-1:0] promote(input logic [ORD_W-1:0] ord,
                                                 input logic [LID_W-1:0] id);
        logic [ORD_W-1:0] o;
        int k;
        o = ord;
        k = 0;
        for (int i = 0; i < TPG; i++) begin
            if (ord[i*LID_W +: LID_W] != id) begin
                o[k*LID_W +: LID_W] = ord[i*LID_W +: LID_W];
                k++;
            end
        end
        o[(TPG-1)*LID_W +: LID_W] = id;
        return o;
    endfunction

    // Decode instruction leaves this cycle unless held
    assign issue = dec_vld && !hold;

    // Order seen by the pick: the thread in decode counts as most recent
    assign view = dec_vld ? promote(rec_q, dec_lid) : rec_q;

    // Least-recently-issued ready thread
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < TPG; i++) begin
            if (!found && ready[view[i*LID_W +: LID_W]]) begin
                found = 1'b1;
                pick  = view[i*LID_W +: LID_W];
            end
        end
    end

    // Recency commit and decode slot load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q   <= init_order();
            dec_vld <= 1'b0;
            dec_lid <= '0;
            dec_cls <= CLS_INT;
        end else begin
            if (issue) rec_q <= promote(rec_q, dec_lid);
            if (!hold) begin
                dec_vld <= found;
                dec_lid <= pick;
                dec_cls <= ins_class_e'(cls_in[pick*CLS_W +: CLS_W]);
            end
        end
    end

endmodule

// File: rtl/dgp_conflict.sv
// Decode-stage check on the load/store and floating-point units.
// The winner of a conflict is the group in pref_q.
// After each conflict pref_q passes to the group that lost.
// Assumes exactly two groups.
module dgp_conflict
    import dgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] vld,
    input  ins_class_e cls0,
    input  ins_class_e cls1,
    output logic [1:0] hold,
    output logic       stall
);
    logic pref_q;
    logic clash;

    // Both slots want the same shared unit
    assign clash = vld[0] && vld[1] && (cls0 == cls1) && needs_shared(cls0);

    // The group not preferred is held on a clash
    always_comb begin
        hold[0] = clash && pref_q;
        hold[1] = clash && !pref_q;
    end

    assign stall = clash;

    // Tie-break passes to the loser after each clash
    always_ff @(posedge clk) begin
        if (!rst_n)     pref_q <= 1'b0;
        else if (clash) pref_q <= ~pref_q;
    end

endmodule

// File: rtl/dual_group_picker.sv
// Top of the dual-group thread pick scheduler.
// Holds two group pick stages, each with its own decode slot,
// and a shared-unit conflict check between the two slots.
// Assumes that ready and class describe each buffer's head each cycle.
module dual_group_picker
    import dgp_pkg::*;
#(
    parameter int THREADS_PER_GROUP = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [2*THREADS_PER_GROUP-1:0]                thr_ready,
    input  logic [2*THREADS_PER_GROUP*CLS_W-1:0]          thr_class,
    output logic [1:0]                                    issue_vld,
    output logic [2*($clog2(THREADS_PER_GROUP)+1)-1:0]    issue_tid,
    output logic                                          stall
);
    localparam int TPG   = THREADS_PER_GROUP;
    localparam int LID_W = $clog2(TPG);
    localparam int TID_W = LID_W + 1;

    logic [1:0]       dec_vld;
    logic [1:0]       hold;
    logic [LID_W-1:0] dec_lid [2];
    ins_class_e       dec_cls [2];

    // One pick stage per static group
    for (genvar g = 0; g < 2; g++) begin : g_grp
        dgp_group_arb #(.TPG(TPG), .LID_W(LID_W)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .ready   (thr_ready[g*TPG +: TPG]),
            .cls_in  (thr_class[g*TPG*CLS_W +: TPG*CLS_W]),
            .hold    (hold[g]),
            .dec_vld (dec_vld[g]),
            .dec_lid (dec_lid[g]),
            .dec_cls (dec_cls[g])
        );
        // Issue outputs, with the group bit on top of the local id
        assign issue_vld[g]                 = dec_vld[g] && !hold[g];
        assign issue_tid[g*TID_W +: TID_W] = {1'(g), dec_lid[g]};
    end

    dgp_conflict u_cfl (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (dec_vld),
        .cls0  (dec_cls[0]),
        .cls1  (dec_cls[1]),
        .hold  (hold),
        .stall (stall)
    );

endmodule

// File: rtl/dgp_checker.sv
// Temporal checks on the scheduler outputs, attached by bind.
// Assumes the default width of three bits per group id.
module dgp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] issue_vld,
    input logic [5:0] issue_tid,
    input logic       stall
);
    // Reset leaves the outputs quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (issue_vld == 2'b00) && !stall);

    // A stall means exactly one group issues
    assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($countones(issue_vld) == 1));

    // Group 0 loser offers the same thread next cycle
    assert_hold_g0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !issue_vld[0]) |=> (issue_tid[2:0] == $past(issue_tid[2:0])));

    // Group 1 loser offers the same thread next cycle
    assert_hold_g1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !issue_vld[1]) |=> (issue_tid[5:3] == $past(issue_tid[5:3])));

    // After group 0 wins, group 1 wins any clash in the next cycle
    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && issue_vld[0]) |=> (!stall || issue_vld[1]));

    // Group 1 always reports ids 4..7 and group 0 ids 0..3
    assert_group_ids_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_tid[5] && !issue_tid[2]);

endmodule

bind dual_group_picker dgp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_vld (issue_vld),
    .issue_tid (issue_tid),
    .stall     (stall)
);

// File: tb/dual_group_picker_bench.sv
// Directed bench for the dual-group thread pick scheduler.
module dual_group_picker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  thr_ready = '0;
    logic [15:0] thr_class = '0;
    logic [1:0]  issue_vld;
    logic [5:0]  issue_tid;
    logic        stall;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dual_group_picker u_dual_group_picker (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_ready (thr_ready),
        .thr_class (thr_class),
        .issue_vld (issue_vld),
        .issue_tid (issue_tid),
        .stall     (stall)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Build a class vector: c0 for the threads in m0, c1 for those in m1
    function automatic logic [15:0] cls_of(input logic [7:0] m0, input logic [1:0] c0,
                                           input logic [7:0] m1, input logic [1:0] c1);
        logic [15:0] v = '0;
        for (int t = 0; t < 8; t++) begin
            if (m0[t]) v[2*t +: 2] = c0;
            if (m1[t]) v[2*t +: 2] = c1;
        end
        return v;
    endfunction

    // Apply inputs, pass one edge, sample just after it
    task automatic step(input logic [7:0] rdy, input logic [15:0] cls);
        @(negedge clk);
        thr_ready = rdy;
        thr_class = cls;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input int vld, input int t0,
                              input int t1, input int stl);
        check({tag, " vld"}, int'(issue_vld), vld);
        check({tag, " stall"}, int'(stall), stl);
        if (vld[0]) check({tag, " tid0"}, int'(issue_tid[2:0]), t0);
        if (vld[1]) check({tag, " tid1"}, int'(issue_tid[5:3]), t1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        thr_ready = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 in reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        thr_ready = '0;
        @(posedge clk);
        #1;
        expect_out("R1 after reset", 0, 0, 0, 0);
    endtask

    task automatic t_round_robin;
        for (int i = 0; i < 4; i++) begin
            step(8'hFF, '0);
            expect_out("R3 R2 R5 rotate", 3, i, 4 + i, 0);
        end
        step(8'h00, '0);
        expect_out("R3 none ready", 0, 0, 0, 0);
    endtask

    task automatic t_sparse;
        step(8'b1010_0100, '0);
        expect_out("R4 sparse a", 3, 2, 5, 0);
        step(8'b1010_0100, '0);
        expect_out("R4 sparse b", 3, 2, 7, 0);
        step(8'h00, '0);
    endtask

    task automatic t_skip;
        step(8'b1110_1110, '0);
        expect_out("R3 R9 skip order", 3, 1, 6, 0);
        step(8'h00, '0);
    endtask

    task automatic t_ldst_conflict;
        logic [15:0] c = cls_of(8'h01, 2'b01, 8'h10, 2'b01);
        step(8'h11, c);
        expect_out("R6 R7 ldst first", 1, 0, 0, 1);
        step(8'h11, c);
        expect_out("R7 ldst second", 2, 0, 4, 1);
        step(8'h11, c);
        expect_out("R7 ldst third", 1, 0, 0, 1);
        step(8'h00, '0);
        expect_out("R8 held issues", 2, 0, 4, 0);
        step(8'h00, '0);
        expect_out("R8 drained", 0, 0, 0, 0);
    endtask

    task automatic t_fp_conflict;
        step(8'h22, cls_of(8'h02, 2'b10, 8'h20, 2'b10));
        expect_out("R7 fp loser wins", 2, 0, 5, 1);
        step(8'h00, '0);
        expect_out("R8 fp held issues", 1, 1, 0, 0);
        step(8'h00, '0);
    endtask

    task automatic t_no_conflict;
        step(8'h44, cls_of(8'h04, 2'b01, 8'h40, 2'b10));
        expect_out("R6 mixed classes", 3, 2, 6, 0);
        step(8'h44, cls_of(8'h04, 2'b11, 8'h40, 2'b11));
        expect_out("R6 reserved class", 3, 2, 6, 0);
        step(8'h44, '0);
        expect_out("R6 integer pair", 3, 2, 6, 0);
        step(8'h00, '0);
    endtask

    task automatic t_held_recency;
        logic [15:0] c = cls_of(8'h08, 2'b01, 8'h90, 2'b01);
        step(8'h98, c);
        expect_out("R7 g0 preferred", 1, 3, 0, 1);
        check("R8 stalled id", int'(issue_tid[5:3]), 7);
        step(8'h90, c);
        expect_out("R8 g1 held issues", 2, 0, 7, 0);
        step(8'h90, c);
        expect_out("R9 next after issue", 2, 0, 4, 0);
        step(8'h00, '0);
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_sparse();
        t_skip();
        t_ldst_conflict();
        t_fp_conflict();
        t_no_conflict();
        t_held_recency();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule